// File: doc/BRIEF.md
# Receive Descriptor Cache with Writeback

This block keeps a circular store of receive descriptors that have already been fetched for a single receive queue. Each descriptor holds a 64-bit packet buffer address and a 64-bit header buffer address. The block tells the descriptor fetcher how many free slots remain, so the fetcher can hold off while the store is full. It also checks that every incoming descriptor carries the ring index the block expects next.

When a packet arrives, the block takes the oldest cached descriptor. One cycle later it issues a data-write request aimed at that descriptor's packet buffer. In the same cycle it issues a writeback for the ring slot of that descriptor, carrying a status word built from three fixed flags and the packet length. A packet that arrives while the store is empty is dropped, and a drop pulse is raised.

Occupancy is tracked by a three-state machine. OCC_EMPTY moves to OCC_PART on an accepted fetch. OCC_PART moves to OCC_FULL when a fetch alone fills the last slot, and back to OCC_EMPTY when a pop alone takes the last entry. OCC_FULL returns to OCC_PART on any pop. In every other case the state does not change.

Top module: `rx_desc_cache`

## Requirements
- R1: `capacity` always equals DEPTH minus the number of cached descriptors. After reset it equals DEPTH, and every output valid or pulse is low.
- R2: Accepted descriptors are consumed in the order they arrived (first in, first out).
- R3: A fetch that is not full and whose `fetch_idx` differs from (first ring index + count) mod RING_LEN is discarded. `idx_err` pulses for one cycle on the following cycle.
- R4: A fetch presented while `capacity` is zero is ignored: nothing is stored, no error is raised, and `capacity` stays zero unless a packet is consumed in the same cycle.
- R5: A packet presented while the cache is empty produces a `pkt_drop` pulse on the next cycle, with no data-write and no writeback.
- R6: One cycle after a packet is consumed, `wr_valid` is high and `wr_addr`, `wr_hdr_addr` and `wr_len` carry the oldest descriptor's addresses and the packet length.
- R7: In that same cycle, `wb_valid` is high and `wb_idx` is the oldest descriptor's ring index. `wb_status` has bit 0 (done), bit 1 (end of packet) and bit 3 (L3/L4 processed) set, the packet length in bits 38 upward (LEN_W bits wide), and every other bit zero.
- R8: The ring index of the oldest descriptor wraps from RING_LEN-1 to 0, and the cache slot position wraps modulo DEPTH.
- R9: An accepted fetch and a consumed packet in the same cycle leave the count unchanged, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched descriptor is presented |
| fetch_idx | input | IDX_W | Ring index of the presented descriptor |
| fetch_pkt_addr | input | AW | Packet buffer address |
| fetch_hdr_addr | input | AW | Header buffer address |
| capacity | output | CNT_W | Free cache slots |
| pkt_valid | input | 1 | A packet has arrived |
| pkt_len | input | LEN_W | Length of the arriving packet in bytes |
| wr_valid | output | 1 | Data-write request |
| wr_addr | output | AW | Packet buffer target of the data write |
| wr_hdr_addr | output | AW | Header buffer of the consumed descriptor |
| wr_len | output | LEN_W | Bytes to write |
| wb_valid | output | 1 | Descriptor writeback request |
| wb_idx | output | IDX_W | Ring slot to write back |
| wb_status | output | 64 | Writeback status word |
| pkt_drop | output | 1 | Packet dropped for lack of a descriptor |
| idx_err | output | 1 | Fetched descriptor had an unexpected ring index |

## Verification
The bench runs the ring index through several wraps, using a ring length that is not a power of two and a small cache. A design that wraps with a bit mask or at the wrong bound would write back to the wrong slot. Fetches are offered while the cache is full, both with good and bad indices, to catch a design that overwrites the oldest entry or raises a false error. Packets are sent to an empty cache, including one that arrives in the same cycle as the first fetch, to catch a design that reads a slot before it is written. A long run of fetches paired with packets checks that simultaneous push and pop neither drift the count nor reorder descriptors.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_EOP_BIT  = 1;
    localparam int STAT_L34_BIT  = 3;
    localparam int STAT_LEN_LSB  = 38;
    localparam int STAT_W        = 64;
endpackage

// File: rtl/rxdc_store.sv
module rxdc_store #(
    parameter int DEPTH = 128,
    parameter int AW    = 64,
    localparam int POS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_slot,
    input  logic [AW-1:0]    wr_pkt,
    input  logic [AW-1:0]    wr_hdr,
    input  logic [POS_W-1:0] rd_slot,
    output logic [AW-1:0]    rd_pkt,
    output logic [AW-1:0]    rd_hdr
);
    logic [AW-1:0] pkt_mem [DEPTH];
    logic [AW-1:0] hdr_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pkt_mem[wr_slot] <= wr_pkt;
            hdr_mem[wr_slot] <= wr_hdr;
        end
    end

    assign rd_pkt = pkt_mem[rd_slot];
    assign rd_hdr = hdr_mem[rd_slot];
endmodule

// File: rtl/rxdc_ptrs.sv
module rxdc_ptrs
    import rxdc_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int RING_LEN = 512,
    localparam int POS_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(RING_LEN),
    localparam int SUM_W = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [IDX_W-1:0] fetch_idx,
    input  logic             pkt_valid,
    output logic             push,
    output logic             pop,
    output logic             drop,
    output logic             bad_idx,
    output logic [POS_W-1:0] slot_w,
    output logic [POS_W-1:0] slot_r,
    output logic [IDX_W-1:0] first_idx,
    output logic [CNT_W-1:0] count
);
    occ_e              state, state_nxt;
    logic [POS_W-1:0]  first_pos;
    logic [SUM_W-1:0]  idx_sum, idx_exp;
    logic              idx_ok, can_push, can_pop;
    logic [CNT_W-1:0]  count_nxt;

    // expected ring index of the next fetched descriptor (RING_LEN >= DEPTH)
    always_comb begin
        idx_sum = SUM_W'(first_idx) + SUM_W'(count);
        idx_exp = (idx_sum >= SUM_W'(RING_LEN)) ? idx_sum - SUM_W'(RING_LEN) : idx_sum;
        idx_ok  = (fetch_idx == idx_exp[IDX_W-1:0]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: if (push) state_nxt = OCC_PART;
            OCC_PART: begin
                if (push && !pop && count == CNT_W'(DEPTH - 1))
                    state_nxt = OCC_FULL;
                else if (pop && !push && count == CNT_W'(1))
                    state_nxt = OCC_EMPTY;
            end
            OCC_FULL:  if (pop) state_nxt = OCC_PART;
            default:   state_nxt = OCC_EMPTY;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        can_push = (state != OCC_FULL);
        can_pop  = (state != OCC_EMPTY);
        push     = fetch_valid && can_push && idx_ok;
        bad_idx  = fetch_valid && can_push && !idx_ok;
        pop      = pkt_valid && can_pop;
        drop     = pkt_valid && !can_pop;
    end

    always_comb begin
        unique case ({push, pop})
            2'b10:   count_nxt = count + CNT_W'(1);
            2'b01:   count_nxt = count - CNT_W'(1);
            default: count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            first_pos <= '0;
            first_idx <= '0;
        end else begin
            count <= count_nxt;
            if (pop) begin
                first_pos <= first_pos + POS_W'(1);
                first_idx <= (first_idx == IDX_W'(RING_LEN - 1)) ? '0 : first_idx + IDX_W'(1);
            end
        end
    end

    assign slot_w = first_pos + count[POS_W-1:0];
    assign slot_r = first_pos;

    AST_FULL_STATE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        state == OCC_FULL |-> count == CNT_W'(DEPTH)); // R4
    AST_EMPTY_STATE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        state == OCC_EMPTY |-> count == '0); // R5
    AST_BOTH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(count)); // R9
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && first_idx == IDX_W'(RING_LEN - 1) |=> first_idx == '0); // R8
endmodule

// File: rtl/rxdc_wb.sv
module rxdc_wb
    import rxdc_pkg::*;
#(
    parameter int AW    = 64,
    parameter int IDX_W = 9,
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              drop,
    input  logic              bad_idx,
    input  logic [AW-1:0]     rd_pkt,
    input  logic [AW-1:0]     rd_hdr,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     wr_hdr_addr,
    output logic [LEN_W-1:0]  wr_len,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [STAT_W-1:0] wb_status,
    output logic              pkt_drop,
    output logic              idx_err
);
    logic [STAT_W-1:0] status_c;

    always_comb begin
        status_c = '0;
        status_c[STAT_DONE_BIT] = 1'b1;
        status_c[STAT_EOP_BIT]  = 1'b1;
        status_c[STAT_L34_BIT]  = 1'b1;
        status_c[STAT_LEN_LSB +: LEN_W] = pkt_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wb_valid <= 1'b0;
            pkt_drop <= 1'b0;
            idx_err  <= 1'b0;
        end else begin
            wr_valid <= pop;
            wb_valid <= pop;
            pkt_drop <= drop;
            idx_err  <= bad_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (pop) begin
            wr_addr     <= rd_pkt;
            wr_hdr_addr <= rd_hdr;
            wr_len      <= pkt_len;
            wb_idx      <= first_idx;
            wb_status   <= status_c;
        end
    end

    AST_POP_GIVES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> wb_valid && wb_idx == $past(first_idx)); // R7
    AST_DROP_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> pkt_drop && !wb_valid && !wr_valid); // R5
    AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |=> idx_err); // R3
endmodule

// File: rtl/rx_desc_cache.sv
module rx_desc_cache
    import rxdc_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int RING_LEN = 512,
    parameter int AW       = 64,
    parameter int LEN_W    = 14,
    localparam int POS_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(RING_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [AW-1:0]     fetch_pkt_addr,
    input  logic [AW-1:0]     fetch_hdr_addr,
    output logic [CNT_W-1:0]  capacity,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     wr_hdr_addr,
    output logic [LEN_W-1:0]  wr_len,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [STAT_W-1:0] wb_status,
    output logic              pkt_drop,
    output logic              idx_err
);
    logic             push, pop, drop, bad_idx;
    logic [POS_W-1:0] slot_w, slot_r;
    logic [IDX_W-1:0] first_idx;
    logic [CNT_W-1:0] count;
    logic [AW-1:0]    rd_pkt, rd_hdr;

    rxdc_ptrs #(.DEPTH(DEPTH), .RING_LEN(RING_LEN)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .pkt_valid(pkt_valid),
        .push(push), .pop(pop), .drop(drop), .bad_idx(bad_idx),
        .slot_w(slot_w), .slot_r(slot_r), .first_idx(first_idx), .count(count)
    );

    rxdc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .wr_en(push), .wr_slot(slot_w),
        .wr_pkt(fetch_pkt_addr), .wr_hdr(fetch_hdr_addr),
        .rd_slot(slot_r), .rd_pkt(rd_pkt), .rd_hdr(rd_hdr)
    );

    rxdc_wb #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .pop(pop), .drop(drop), .bad_idx(bad_idx),
        .rd_pkt(rd_pkt), .rd_hdr(rd_hdr), .first_idx(first_idx), .pkt_len(pkt_len),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_hdr_addr(wr_hdr_addr), .wr_len(wr_len),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_status(wb_status),
        .pkt_drop(pkt_drop), .idx_err(idx_err)
    );

    assign capacity = CNT_W'(DEPTH) - count;

    AST_FULL_FETCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && capacity == '0 && !pkt_valid |=> capacity == '0 && !idx_err); // R4
    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        capacity <= CNT_W'(DEPTH)); // R1
endmodule

// File: tb/rx_desc_cache_tb_top.sv
`timescale 1ns/1ps
module rx_desc_cache_tb_top;
    localparam int DEPTH    = 8;
    localparam int RING_LEN = 12;
    localparam int AW       = 64;
    localparam int LEN_W    = 14;
    localparam int IDX_W    = $clog2(RING_LEN);
    localparam int CNT_W    = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [IDX_W-1:0]  fetch_idx = '0;
    logic [AW-1:0]     fetch_pkt_addr = '0;
    logic [AW-1:0]     fetch_hdr_addr = '0;
    logic [CNT_W-1:0]  capacity;
    logic              pkt_valid = 1'b0;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic              wr_valid, wb_valid, pkt_drop, idx_err;
    logic [AW-1:0]     wr_addr, wr_hdr_addr;
    logic [LEN_W-1:0]  wr_len;
    logic [IDX_W-1:0]  wb_idx;
    logic [63:0]       wb_status;

    always #2.5 clk = ~clk;

    rx_desc_cache #(.DEPTH(DEPTH), .RING_LEN(RING_LEN), .AW(AW), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
        .fetch_pkt_addr(fetch_pkt_addr), .fetch_hdr_addr(fetch_hdr_addr),
        .capacity(capacity), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_hdr_addr(wr_hdr_addr), .wr_len(wr_len),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_status(wb_status),
        .pkt_drop(pkt_drop), .idx_err(idx_err)
    );

    localparam int EV_WB = 0, EV_DROP = 1, EV_ERR = 2;
    typedef struct { int kind; int idx; logic [63:0] pkt; logic [63:0] hdr; int len; } ev_t;
    typedef struct { logic [63:0] pkt; logic [63:0] hdr; } dsc_t;

    ev_t  exp_q[$];
    dsc_t cache_q[$];
    int   m_first = 0;
    int   addr_seq = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;
    ev_t  mon_e;

    task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_status(int len);
        logic [63:0] s;
        s = '0;
        s[0] = 1'b1;
        s[1] = 1'b1;
        s[3] = 1'b1;
        s[38 +: LEN_W] = LEN_W'(len);
        return s;
    endfunction

    // driver: one cycle of stimulus, expected results go to the scoreboard
    task automatic step(bit do_f, bit bad, bit do_p, int len);
        int   nidx;
        int   pre_cnt;
        ev_t  e;
        dsc_t d;
        @(negedge clk);
        pre_cnt = cache_q.size();
        chk(capacity == CNT_W'(DEPTH - pre_cnt), "R1", "capacity", capacity, DEPTH - pre_cnt);
        nidx = (m_first + pre_cnt) % RING_LEN;
        addr_seq++;
        d.pkt = 64'hA000_0000_0000_0000 + 64'(addr_seq) * 64'h1000;
        d.hdr = 64'h0000_00B0_0000_0000 + 64'(addr_seq) * 64'h40;
        fetch_valid    = do_f;
        fetch_idx      = IDX_W'(bad ? (nidx + 5) % RING_LEN : nidx);
        fetch_pkt_addr = d.pkt;
        fetch_hdr_addr = d.hdr;
        pkt_valid      = do_p;
        pkt_len        = LEN_W'(len);
        if (do_f && pre_cnt < DEPTH && bad) begin
            e = '{kind: EV_ERR, idx: 0, pkt: '0, hdr: '0, len: 0};
            exp_q.push_back(e);
        end
        if (do_p) begin
            if (pre_cnt == 0) begin
                e = '{kind: EV_DROP, idx: 0, pkt: '0, hdr: '0, len: 0};
                exp_q.push_back(e);
            end else begin
                dsc_t o;
                o = cache_q.pop_front();
                e = '{kind: EV_WB, idx: m_first, pkt: o.pkt, hdr: o.hdr, len: len};
                exp_q.push_back(e);
                m_first = (m_first + 1) % RING_LEN;
            end
        end
        if (do_f && pre_cnt < DEPTH && !bad) cache_q.push_back(d);
    endtask

    // monitor: compares registered outputs with the scoreboard
    always @(negedge clk) begin
        if (running) begin
            if (idx_err) begin
                if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected idx_err", 1, 0);
                else begin
                    mon_e = exp_q.pop_front();
                    chk(mon_e.kind == EV_ERR, "R3", "event kind", mon_e.kind, EV_ERR);
                end
            end
            if (wb_valid || wr_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected write", 1, 0);
                else begin
                    mon_e = exp_q.pop_front();
                    chk(mon_e.kind == EV_WB, "R2", "event kind", mon_e.kind, EV_WB);
                    chk(wb_valid && wr_valid, "R6", "both requests", {wb_valid, wr_valid}, 2'b11);
                    chk(wr_addr == mon_e.pkt, "R2", "wr_addr order", wr_addr, mon_e.pkt);
                    chk(wr_hdr_addr == mon_e.hdr, "R6", "wr_hdr_addr", wr_hdr_addr, mon_e.hdr);
                    chk(wr_len == LEN_W'(mon_e.len), "R6", "wr_len", wr_len, mon_e.len);
                    chk(wb_idx == IDX_W'(mon_e.idx), "R8", "wb_idx", wb_idx, mon_e.idx);
                    chk(wb_status == exp_status(mon_e.len), "R7", "wb_status",
                        wb_status, exp_status(mon_e.len));
                end
            end
            if (pkt_drop) begin
                if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected drop", 1, 0);
                else begin
                    mon_e = exp_q.pop_front();
                    chk(mon_e.kind == EV_DROP, "R5", "event kind", mon_e.kind, EV_DROP);
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(capacity == CNT_W'(DEPTH), "R1", "reset capacity", capacity, DEPTH);
        chk(!wb_valid && !wr_valid && !pkt_drop && !idx_err, "R1", "reset outputs",
            {wb_valid, wr_valid, pkt_drop, idx_err}, 0);
        running = 1'b1;

        step(0, 0, 1, 64);                          // R5 drop on empty
        step(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0); // R2 fill
        step(1, 1, 0, 0);                           // R3 bad index
        step(0, 0, 0, 0);
        step(0, 0, 1, 100);                         // R6 R7 consume
        step(0, 0, 1, 16383);                       // R7 max length
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0); // reach full
        step(1, 0, 0, 0);                           // R4 full, ignored
        step(1, 1, 0, 0);                           // R4 full, bad index, no error
        step(0, 0, 0, 0);
        step(1, 0, 1, 200);                         // R4 full with pop
        for (int i = 0; i < 40; i++) step(1, 0, 1, 60 + i); // R9 R8 paired traffic
        for (int i = 0; i < 7; i++) step(0, 0, 1, 300 + i); // drain
        step(0, 0, 1, 9);                           // R5 empty again
        step(0, 0, 0, 0);
        step(1, 0, 1, 77);                          // R5 same-cycle fill and drop
        step(0, 0, 1, 78);                          // R2 consume that one
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        chk(exp_q.size() == 0, "R6", "pending expected events", exp_q.size(), 0);
        chk(capacity == CNT_W'(DEPTH), "R1", "final capacity", capacity, DEPTH);
        done = 1'b1;
        finish_run();
    end
endmodule